// File: doc/BRIEF.md
# Converter Serial Port with Daisy-Chain

This block is the digital half of a 14-bit sampling converter's serial port, written as a synchronous design. A system clock samples the convert strobe, the serial clock and the serial data input through two-stage synchronisers. A rising convert strobe starts a conversion of fixed length, measured in system clocks. At the same edge the port reads the serial input and serial clock levels. Those levels choose between two modes. In select mode a host reads one converter with an active-low select. In chained mode several converters are cascaded onto one data line.

When the conversion ends, the port loads the result. The result comes from a behavioural signed sample input and is clamped to 14-bit straight binary. The port shifts the result out MSB first, changing the data on serial clock falling edges. An output-enable flag stands in for the high-impedance state of a pad. In chained mode, the data shifted in from upstream converters follows the local result on the same line. Either mode can put an optional start bit ahead of the data, so the host knows when data is ready.

Top module: `sar_serial_port`

## Requirements
- R1: After reset, `sdo_oe_o`, `sdo_o` and `busy_o` are all low.
- R2: The `sdi_i` level just before the synchronised `cnv_i` rising edge picks the mode: high selects select mode and low selects chained mode. If `sdi_i` and `cnv_i` rise together, chained mode is chosen.
- R3: `busy_o` is high for exactly CONV_CYCLES system clocks after an accepted `cnv_i` rise. Further `cnv_i` rises during that window neither restart nor extend it.
- R4: The signed sample is coded as straight binary. Values above 16383 give 0x3FFF and negative values give 0x0000. Bits are sent MSB first.
- R5: In select mode without the start bit, the output stays disabled until select becomes active. Select is active when `cnv_i` or `sdi_i` is low. The MSB then appears, each `sck_i` falling edge moves to the next bit, and the output is disabled after the 14th falling edge.
- R6: In select mode, if select is active when the conversion ends, the output is enabled and driven low as a start bit. The first falling edge brings the MSB, and the output is disabled after the 15th falling edge.
- R7: In select mode, deactivating select during readout disables the output at once. Reactivating it brings nothing out until the next conversion.
- R8: In chained mode with `sck_i` low at the `cnv_i` rise, the MSB is on `sdo_o` when the conversion ends. The `sdi_i` level sampled at falling edge k appears on `sdo_o` after falling edge k+13.
- R9: In chained mode with `sck_i` high at the `cnv_i` rise, `sdo_o` is low after the conversion until `sdi_i` goes high, then high. The next falling edge brings the MSB.
- R10: In chained mode, `sdo_o` is low whenever `cnv_i` and `sdi_i` are both low.
- R11: The output is disabled for the whole conversion in select mode. It stays enabled from the `cnv_i` rise in chained mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnv_i | input | 1 | Convert strobe, asynchronous |
| sck_i | input | 1 | Serial clock, asynchronous |
| sdi_i | input | 1 | Serial data / select input, asynchronous |
| sample_i | input | SAMPLE_W | Signed behavioural sample value |
| sdo_o | output | 1 | Serial data output |
| sdo_oe_o | output | 1 | Output enable; low stands for high impedance |
| busy_o | output | 1 | High while the conversion timer runs |

## Verification
Two things can happen in the same part of the timeline: the end of a conversion and a change of the select line, or a new `cnv_i` rise. The bench pulls `sdi_i` low while the conversion is still running. The end-of-conversion decision then sees an active select, and the first output observed must be a low start bit rather than the MSB. The bench also drops and raises `cnv_i` in the middle of the same conversion. The measured `busy_o` pulse must still be exactly CONV_CYCLES clocks long, which shows that the second rise was ignored.

// File: rtl/sar_port_pkg.sv
package sar_port_pkg;

    typedef enum logic {
        MODE_SEL   = 1'b0,
        MODE_CHAIN = 1'b1
    } port_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_CONV     = 3'd1,
        ST_WAIT_SEL = 3'd2,
        ST_WAIT_UP  = 3'd3,
        ST_START    = 3'd4,
        ST_SHIFT    = 3'd5,
        ST_DONE     = 3'd6
    } port_state_e;

endpackage

// File: rtl/sar_in_sync.sv
module sar_in_sync #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] level_o,
    output logic [N-1:0] prev_o
);

    typedef struct packed {
        logic [N-1:0] meta;
        logic [N-1:0] sync;
        logic [N-1:0] prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.meta = async_i;
        s_d.sync = s_q.meta;
        s_d.prev = s_q.sync;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign level_o = s_q.sync;
    assign prev_o  = s_q.prev;

endmodule

// File: rtl/sar_conv_timer.sv
module sar_conv_timer #(
    parameter int CONV_CYCLES = 220
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o,
    output logic done_o
);

    localparam int CW = $clog2(CONV_CYCLES + 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (t_q.busy) begin
            if (t_q.cnt == '0) t_d.busy = 1'b0;
            else               t_d.cnt  = t_q.cnt - 1'b1;
        end else if (start_i) begin
            t_d.busy = 1'b1;
            t_d.cnt  = CW'(CONV_CYCLES - 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign busy_o = t_q.busy;
    assign done_o = t_q.busy && (t_q.cnt == '0);

    // R3: the final count ends the busy window
    p_done_ends_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o);

    // R3: a running count never stalls and never drops busy early
    p_count_steps_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (t_q.busy && t_q.cnt != '0) |=> (t_q.busy && t_q.cnt == $past(t_q.cnt) - 1'b1));

endmodule

// File: rtl/sar_result_clamp.sv
module sar_result_clamp #(
    parameter int SW = 16,
    parameter int DW = 14
) (
    input  logic signed [SW-1:0] sample_i,
    output logic        [DW-1:0] code_o
);

    localparam logic signed [SW-1:0] CODE_MAX = SW'((1 << DW) - 1);

    always_comb begin
        if (sample_i < 0)             code_o = '0;
        else if (sample_i > CODE_MAX) code_o = '1;
        else                          code_o = sample_i[DW-1:0];
    end

endmodule

// File: rtl/sar_serial_fsm.sv
module sar_serial_fsm
    import sar_port_pkg::*;
#(
    parameter int DW = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          done_i,
    input  logic          busy_i,
    input  logic          cnv_i,
    input  logic          sdi_i,
    input  logic          sdi_prev_i,
    input  logic          sck_prev_i,
    input  logic          sck_fall_i,
    input  logic [DW-1:0] code_i,
    output logic          sdo_o,
    output logic          sdo_oe_o
);

    localparam int CNT_W = $clog2(DW);

    typedef struct packed {
        port_state_e      state;
        port_mode_e       mode;
        logic             lead_bit;
        logic [DW-1:0]    shreg;
        logic [CNT_W-1:0] cnt;
    } port_t;

    port_t p_d, p_q;
    logic  sel_act;

    assign sel_act = !cnv_i || !sdi_i;

    always_comb begin
        p_d = p_q;
        if (start_i && !busy_i) begin
            p_d.state    = ST_CONV;
            p_d.mode     = sdi_prev_i ? MODE_SEL : MODE_CHAIN;
            p_d.lead_bit = sck_prev_i;
            p_d.cnt      = '0;
        end else begin
            unique case (p_q.state)
                ST_CONV: begin
                    if (done_i) begin
                        p_d.shreg = code_i;
                        p_d.cnt   = '0;
                        if (p_q.mode == MODE_SEL)
                            p_d.state = sel_act ? ST_START : ST_WAIT_SEL;
                        else
                            p_d.state = p_q.lead_bit ? ST_WAIT_UP : ST_SHIFT;
                    end
                end
                ST_WAIT_SEL: begin
                    if (sel_act) p_d.state = ST_SHIFT;
                end
                ST_WAIT_UP: begin
                    if (sdi_i) p_d.state = ST_START;
                end
                ST_START: begin
                    if (p_q.mode == MODE_SEL && !sel_act) p_d.state = ST_DONE;
                    else if (sck_fall_i)                  p_d.state = ST_SHIFT;
                end
                ST_SHIFT: begin
                    if (p_q.mode == MODE_SEL) begin
                        if (!sel_act) begin
                            p_d.state = ST_DONE;
                        end else if (sck_fall_i) begin
                            if (p_q.cnt == CNT_W'(DW - 1)) begin
                                p_d.state = ST_DONE;
                            end else begin
                                p_d.shreg = {p_q.shreg[DW-2:0], 1'b0};
                                p_d.cnt   = p_q.cnt + 1'b1;
                            end
                        end
                    end else if (sck_fall_i) begin
                        p_d.shreg = {p_q.shreg[DW-2:0], sdi_i};
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q.state    <= ST_IDLE;
            p_q.mode     <= MODE_SEL;
            p_q.lead_bit <= 1'b0;
            p_q.shreg    <= '0;
            p_q.cnt      <= '0;
        end else begin
            p_q <= p_d;
        end
    end

    always_comb begin
        if (p_q.mode == MODE_CHAIN) sdo_oe_o = (p_q.state != ST_IDLE);
        else                        sdo_oe_o = (p_q.state == ST_START) || (p_q.state == ST_SHIFT);
        unique case (p_q.state)
            ST_START: sdo_o = (p_q.mode == MODE_CHAIN);
            ST_SHIFT: sdo_o = p_q.shreg[DW-1];
            default:  sdo_o = 1'b0;
        endcase
        if (p_q.mode == MODE_CHAIN && !cnv_i && !sdi_i) sdo_o = 1'b0;
    end

    // R3: the port sits in conversion exactly while the timer runs
    p_conv_with_timer_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (p_q.state == ST_CONV) == busy_i);

    // R11: no select-mode output while the timer runs
    p_sel_quiet_conv_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && p_q.mode == MODE_SEL) |-> !sdo_oe_o);

    // R5: the falling edge after the last data bit disables the output
    p_last_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (p_q.mode == MODE_SEL && p_q.state == ST_SHIFT && sel_act && sck_fall_i
         && p_q.cnt == CNT_W'(DW - 1)) |=> !sdo_oe_o);

    // R7: releasing select during readout disables the output
    p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (p_q.mode == MODE_SEL && sdo_oe_o && !sel_act) |=> !sdo_oe_o);

endmodule

// File: rtl/sar_serial_port.sv
module sar_serial_port #(
    parameter int DATA_W      = 14,
    parameter int SAMPLE_W    = 16,
    parameter int CONV_CYCLES = 220
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cnv_i,
    input  logic                       sck_i,
    input  logic                       sdi_i,
    input  logic signed [SAMPLE_W-1:0] sample_i,
    output logic                       sdo_o,
    output logic                       sdo_oe_o,
    output logic                       busy_o
);

    localparam int N_IN = 3;
    localparam int I_CNV = 0;
    localparam int I_SCK = 1;
    localparam int I_SDI = 2;

    logic [N_IN-1:0]   lvl, prv;
    logic              cnv_rise, sck_fall, conv_start, conv_done;
    logic [DATA_W-1:0] code;

    sar_in_sync #(.N(N_IN)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({sdi_i, sck_i, cnv_i}),
        .level_o (lvl),
        .prev_o  (prv)
    );

    assign cnv_rise   = lvl[I_CNV] && !prv[I_CNV];
    assign sck_fall   = !lvl[I_SCK] && prv[I_SCK];
    assign conv_start = cnv_rise && !busy_o;

    sar_conv_timer #(.CONV_CYCLES(CONV_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (conv_start),
        .busy_o  (busy_o),
        .done_o  (conv_done)
    );

    sar_result_clamp #(.SW(SAMPLE_W), .DW(DATA_W)) u_clamp (
        .sample_i (sample_i),
        .code_o   (code)
    );

    sar_serial_fsm #(.DW(DATA_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (conv_start),
        .done_i     (conv_done),
        .busy_i     (busy_o),
        .cnv_i      (lvl[I_CNV]),
        .sdi_i      (lvl[I_SDI]),
        .sdi_prev_i (prv[I_SDI]),
        .sck_prev_i (prv[I_SCK]),
        .sck_fall_i (sck_fall),
        .code_i     (code),
        .sdo_o      (sdo_o),
        .sdo_oe_o   (sdo_oe_o)
    );

    // R3: an accepted strobe starts the timer on the next edge
    p_start_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> busy_o);

    // R2: serial input low before the strobe gives the always-driven chained mode
    p_chain_pick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_start && !prv[I_SDI]) |=> sdo_oe_o);

endmodule

// File: tb/sar_serial_port_tb.sv
module sar_serial_port_tb;

    localparam int DW = 14;
    localparam int SW = 16;
    localparam int CC = 220;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 cnv = 1'b0;
    logic                 sck = 1'b0;
    logic                 sdi = 1'b0;
    logic signed [SW-1:0] sample = '0;
    logic                 sdo, oe, busy;

    int checks = 0;
    int fails = 0;
    int run_len = 0;
    int last_len = 0;

    typedef struct {
        string tag;
        logic  eoe;
        logic  ebit;
    } exp_t;

    exp_t exp_q[$];

    always #5 clk = ~clk;

    sar_serial_port #(.DATA_W(DW), .SAMPLE_W(SW), .CONV_CYCLES(CC)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnv_i    (cnv),
        .sck_i    (sck),
        .sdi_i    (sdi),
        .sample_i (sample),
        .sdo_o    (sdo),
        .sdo_oe_o (oe),
        .busy_o   (busy)
    );

    always @(posedge clk) begin
        if (busy) run_len <= run_len + 1;
        else if (run_len != 0) begin
            last_len <= run_len;
            run_len  <= 0;
        end
    end

    // monitor: pops expected output items and compares them
    always @(negedge clk) begin : monitor
        exp_t e;
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            checks++;
            if (oe !== e.eoe || (e.eoe && sdo !== e.ebit)) begin
                fails++;
                $display("FAIL %s actual oe=%b sdo=%b expected oe=%b sdo=%b",
                         e.tag, oe, sdo, e.eoe, e.ebit);
            end
        end
    end

    task automatic expect_out(string tag, logic eoe, logic ebit);
        exp_t e;
        e.tag  = tag;
        e.eoe  = eoe;
        e.ebit = ebit;
        exp_q.push_back(e);
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic chk(string tag, int act, int expv);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic settle();
        repeat (8) @(negedge clk);
    endtask

    task automatic sck_pulse();
        sck = 1'b1;
        settle();
        sck = 1'b0;
        settle();
    endtask

    task automatic wait_conv();
        repeat (CC + 12) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R3 actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : driver
        logic [DW-1:0] v1, v2, v3;
        logic [19:0]   pat;
        v1  = 14'h25A3;
        v2  = 14'h1B6D;
        v3  = 14'h2000;
        pat = 20'h5A3CD;

        repeat (5) @(negedge clk);
        expect_out("R1 reset oe", 1'b0, 1'b0);
        chk("R1 reset busy", int'(busy), 0);
        chk("R1 reset sdo", int'(sdo), 0);
        rst_n = 1'b1;
        settle();

        // select mode, no start bit
        sample = SW'(v1);
        sdi = 1'b1;
        settle();
        cnv = 1'b1;
        settle();
        expect_out("R11 select mode idle in conversion", 1'b0, 1'b0);
        chk("R3 busy during conversion", int'(busy), 1);
        wait_conv();
        chk("R3 busy length", last_len, CC);
        expect_out("R5 waits for select", 1'b0, 1'b0);
        cnv = 1'b0;
        settle();
        expect_out("R5 msb on select", 1'b1, v1[DW-1]);
        for (int k = 1; k < DW; k++) begin
            sck_pulse();
            expect_out("R5 data bit", 1'b1, v1[DW-1-k]);
        end
        sck_pulse();
        expect_out("R5 disabled after 14th edge", 1'b0, 1'b0);

        // sdi tied to cnv: chained mode
        sdi = 1'b0;
        settle();
        cnv = 1'b1;
        sdi = 1'b1;
        settle();
        expect_out("R2 tied strobe picks chain", 1'b1, 1'b0);
        wait_conv();
        expect_out("R8 msb after conversion", 1'b1, v1[DW-1]);

        // select mode with start bit, strobe re-rise ignored, clamp high
        cnv = 1'b0;
        sdi = 1'b1;
        settle();
        sample = 16'sd20000;
        cnv = 1'b1;
        repeat (40) @(negedge clk);
        cnv = 1'b0;
        settle();
        cnv = 1'b1;
        settle();
        sdi = 1'b0;
        wait_conv();
        chk("R3 busy length with re-rise", last_len, CC);
        expect_out("R6 start bit", 1'b1, 1'b0);
        for (int k = 1; k <= DW; k++) begin
            sck_pulse();
            expect_out("R4 R6 clamped high bit", 1'b1, 1'b1);
        end
        sck_pulse();
        expect_out("R6 disabled after 15th edge", 1'b0, 1'b0);

        // select mode aborted, clamp low
        sdi = 1'b1;
        cnv = 1'b0;
        settle();
        sample = -16'sd5;
        cnv = 1'b1;
        settle();
        wait_conv();
        expect_out("R5 deselected after conversion", 1'b0, 1'b0);
        sdi = 1'b0;
        settle();
        expect_out("R4 clamped low msb", 1'b1, 1'b0);
        sck_pulse();
        expect_out("R4 clamped low bit", 1'b1, 1'b0);
        sck_pulse();
        expect_out("R4 clamped low bit", 1'b1, 1'b0);
        sdi = 1'b1;
        settle();
        expect_out("R7 release disables", 1'b0, 1'b0);
        sdi = 1'b0;
        settle();
        expect_out("R7 no second readout", 1'b0, 1'b0);

        // chained mode, no start bit, delay line
        cnv = 1'b0;
        sck = 1'b0;
        settle();
        sample = SW'(v2);
        cnv = 1'b1;
        settle();
        expect_out("R11 chain driven in conversion", 1'b1, 1'b0);
        wait_conv();
        expect_out("R8 msb at conversion end", 1'b1, v2[DW-1]);
        for (int k = 1; k <= 20; k++) begin
            sdi = pat[k-1];
            sck_pulse();
            if (k < DW) expect_out("R8 result bit", 1'b1, v2[DW-1-k]);
            else        expect_out("R8 delayed sdi bit", 1'b1, pat[k-DW]);
        end
        sdi = 1'b0;
        cnv = 1'b0;
        settle();
        expect_out("R10 low with cnv and sdi low", 1'b1, 1'b0);
        sdi = 1'b1;
        settle();
        expect_out("R10 data back with sdi high", 1'b1, pat[6]);

        // chained mode with start bit
        sdi = 1'b0;
        sck = 1'b1;
        settle();
        sample = SW'(v3);
        cnv = 1'b1;
        settle();
        sck = 1'b0;
        settle();
        wait_conv();
        expect_out("R9 low until upstream done", 1'b1, 1'b0);
        sdi = 1'b1;
        settle();
        expect_out("R9 high when sdi high", 1'b1, 1'b1);
        sdi = 1'b0;
        sck_pulse();
        expect_out("R9 msb after start bit", 1'b1, v3[DW-1]);
        sck_pulse();
        expect_out("R9 second bit", 1'b1, v3[DW-2]);

        repeat (4) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule